// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeping Core

This block keeps the time of day and the calendar date in seven packed-BCD registers: seconds, minutes, hours, day of week, date, month with a century flag, and year. A prescaler counts pulses of an oscillator enable input. Every `TICKS_PER_SEC` pulses it advances the time by one second. The advance carries through minutes, hours, the day of week, the date with month lengths and leap years, the month and the year. When the year wraps from 99 to 00, the century flag flips.

Software writes one register per cycle with a write strobe, an address and a data byte. Reads return the register chosen by the same address in the same cycle. The hours register has two encodings. In 12-hour form it carries an AM/PM flag. In 24-hour form that same bit is the top tens-of-hours bit. A write to the seconds register restarts the sub-second count, which re-phases the 1 Hz square wave. A one-cycle pulse marks each cycle in which freshly advanced values first appear, so that alarm logic downstream can compare on it. Illegal BCD values give undefined results and are not detected.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the registers read seconds 00h, minutes 00h, hours 00h (24-hour midnight), day of week 01h, date 01h, month 01h with century 0, and year 00h.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write stores the byte under a per-register mask:
  - seconds, minutes and hours keep bits 6:0;
  - day of week keeps bits 2:0;
  - date keeps bits 5:0;
  - month keeps bits 7 and 4:0;
  - year keeps all bits.
  
  Address 7 reads 00h.
- R3: Seconds advance by one after every TICKS_PER_SEC oscillator-enable pulses. `sec_pulse` is high for exactly the one cycle in which the advanced values first read back.
- R4: Seconds and minutes count 00 to 59, and the wrap to 00 carries into the next register.
- R5: In 24-hour mode (hours bit 6 = 0, bit 5 = tens-of-hours bit for 20 to 23), hour 23 wraps to 00 and advances the day.
- R6: In 12-hour mode (hours bit 6 = 1, bit 5 = PM when 1), the hour runs 12, 1, … 11. The PM flag flips on 11 to 12, and the day advances on 11 PM to 12 AM.
- R7: The day of week steps 1 to 7 and wraps from 7 to 1, only at midnight.
- R8: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February wraps after 28, or after 29 when the BCD year is divisible by 4. A date wrap advances the month.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and flips month bit 7 (century).
- R10: A seconds write restarts the sub-second count. `sqw_1hz` is low in the following cycle and goes high after TICKS_PER_SEC/2 further pulses. The next advance comes after TICKS_PER_SEC pulses.
- R11: With `sqw_en` low, `sqw_1hz` stays low.
- R12: A write in the same cycle as an advance wins for the written register. The other registers still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| sqw_en | input | 1 | Enables the 1 Hz square wave |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr`, same cycle |
| sqw_1hz | output | 1 | 1 Hz square wave aligned to the seconds advance |
| sec_pulse | output | 1 | One-cycle pulse when advanced values are first visible |

## Verification
Read data follows `addr` in the same cycle. A write shows up one clock edge after its strobe is sampled. An advance shows up right after the edge that samples the TICKS_PER_SEC-th oscillator pulse, and `sec_pulse` rises in that same cycle. `sqw_1hz` follows the sub-second count combinationally, so it changes one edge after the pulse that moves the count across its midpoint. A behavioural model in the bench steps on every rising edge with the same inputs, and the outputs are compared at the falling edge. Directed reads sample 5 ns after the edge that follows the address change, so each comparison lands in the cycle where the result is due.

// File: rtl/tk_pkg.sv
// Shared constants and BCD helpers for the timekeeping core.
// Assumes packed BCD bytes; illegal digits are not screened.
package tk_pkg;
    localparam int REG_COUNT = 7;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;

    localparam int A_SEC  = 0;
    localparam int A_MIN  = 1;
    localparam int A_HOUR = 2;
    localparam int A_DOW  = 3;
    localparam int A_DATE = 4;
    localparam int A_MON  = 5;
    localparam int A_YEAR = 6;

    // Add one to a packed BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Step a BCD counter: {carry, next}; wraps from top to low.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] low);
        if (v == top) return {1'b1, low};
        return {1'b0, bcd_inc(v)};
    endfunction

    // Last day of the month as BCD; leap years are BCD years divisible by 4.
    function automatic logic [7:0] month_last(input logic [4:0] mon,
                                              input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
        case (mon)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Bits kept when software writes a register.
    function automatic logic [7:0] wr_mask(input int idx);
        case (idx)
            A_SEC, A_MIN, A_HOUR: return 8'h7F;
            A_DOW:                return 8'h07;
            A_DATE:               return 8'h3F;
            A_MON:                return 8'h9F;
            default:              return 8'hFF;
        endcase
    endfunction

    // Register contents after reset.
    function automatic logic [7:0] reset_val(input int idx);
        case (idx)
            A_DOW, A_DATE, A_MON: return 8'h01;
            default:              return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/tk_prescaler.sv
// Sub-second prescaler: counts oscillator-enable pulses and issues a
// one-cycle tick on the last pulse of each second. A restart clears the
// count, which also re-phases the square wave (high in the second half).
// Assumes TICKS >= 2.
module tk_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic restart,
    input  logic sqw_en,
    output logic tick,
    output logic sqw
);
    localparam int CNT_W = $clog2(TICKS);
    localparam int HALF  = TICKS / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == CNT_W'(TICKS - 1));
    // Tick on the final pulse of a second unless a restart cancels it.
    assign tick = osc_en && last && !restart;
    // Square wave: high for the second half of each second.
    assign sqw  = sqw_en && (cnt_q >= CNT_W'(HALF));

    // Count oscillator pulses modulo TICKS; restart has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (osc_en)  cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < (CNT_W+1)'(TICKS)); // R3
    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sqw); // R10
endmodule

// File: rtl/tk_time_next.sv
// Combinational next-second calculator: from the current register bank
// it forms the bank one second later, with the full carry chain through
// hours (12/24-hour), day of week, date, month, year and century.
// Assumes legal BCD contents; illegal values give undefined results.
module tk_time_next
    import tk_pkg::*;
(
    input  logic [REG_COUNT-1:0][7:0] cur,
    output logic [REG_COUNT-1:0][7:0] nxt
);
    logic [8:0] s_sec, s_min, s_h24, s_dow, s_date, s_mon, s_year;
    logic [7:0] hour_nxt;
    logic       c_hour, c_day;

    // Seconds, minutes and 24-hour steps (each uses its own carry in).
    always_comb begin
        s_sec  = bcd_step({1'b0, cur[A_SEC][6:0]}, 8'h59, 8'h00);
        s_min  = bcd_step({1'b0, cur[A_MIN][6:0]}, 8'h59, 8'h00);
        s_h24  = bcd_step({2'b0, cur[A_HOUR][5:0]}, 8'h23, 8'h00);
        c_hour = s_sec[8] && s_min[8];
    end

    // Hour step in either encoding; reports the midnight carry.
    always_comb begin
        hour_nxt = cur[A_HOUR];
        c_day    = 1'b0;
        if (cur[A_HOUR][6]) begin
            if (cur[A_HOUR][4:0] == 5'h12) begin
                hour_nxt = {2'b01, cur[A_HOUR][5], 5'h01};
            end else if (cur[A_HOUR][4:0] == 5'h11) begin
                hour_nxt = {2'b01, ~cur[A_HOUR][5], 5'h12};
                c_day    = cur[A_HOUR][5];
            end else begin
                hour_nxt = {2'b01, cur[A_HOUR][5], bcd_inc({3'b0, cur[A_HOUR][4:0]})[4:0]};
            end
        end else begin
            hour_nxt = {2'b00, s_h24[5:0]};
            c_day    = s_h24[8];
        end
    end

    // Calendar steps: day of week, date by month length, month, year.
    always_comb begin
        s_dow  = bcd_step({5'b0, cur[A_DOW][2:0]}, 8'h07, 8'h01);
        s_date = bcd_step({2'b0, cur[A_DATE][5:0]},
                          month_last(cur[A_MON][4:0], cur[A_YEAR]), 8'h01);
        s_mon  = bcd_step({3'b0, cur[A_MON][4:0]}, 8'h12, 8'h01);
        s_year = bcd_step(cur[A_YEAR], 8'h99, 8'h00);
    end

    // Assemble the advanced bank along the carry chain.
    always_comb begin
        nxt = cur;
        nxt[A_SEC] = s_sec[7:0];
        if (s_sec[8]) nxt[A_MIN] = s_min[7:0];
        if (c_hour) nxt[A_HOUR] = hour_nxt;
        if (c_hour && c_day) begin
            nxt[A_DOW]  = s_dow[7:0];
            nxt[A_DATE] = s_date[7:0];
            if (s_date[8]) begin
                nxt[A_MON] = {cur[A_MON][7], s_mon[6:0]};
                if (s_mon[8]) begin
                    nxt[A_YEAR] = s_year[7:0];
                    if (s_year[8]) nxt[A_MON][7] = ~cur[A_MON][7];
                end
            end
        end
    end
endmodule

// File: rtl/bcd_timekeeper.sv
// Top of the BCD clock-calendar core: seven BCD registers with a
// per-cycle write port and same-cycle readback, advanced once per second
// by the prescaler. A write wins over an advance for its own register.
// Assumes one register write per cycle; addresses above 6 read as zero.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              sqw_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sqw_1hz,
    output logic              sec_pulse
);
    logic [REG_COUNT-1:0][7:0] regs_q;
    logic [REG_COUNT-1:0][7:0] regs_adv;
    logic                      tick;
    logic                      sec_wr;

    assign sec_wr = wr_en && (addr == ADDR_W'(A_SEC));

    tk_prescaler #(.TICKS(TICKS_PER_SEC)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .restart (sec_wr),
        .sqw_en  (sqw_en),
        .tick    (tick),
        .sqw     (sqw_1hz)
    );

    tk_time_next u_next (
        .cur (regs_q),
        .nxt (regs_adv)
    );

    // Register bank: reset, masked write, or one-second advance.
    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_COUNT; i++) begin
            if (!rst_n)                             regs_q[i] <= reset_val(i);
            else if (wr_en && addr == ADDR_W'(i))   regs_q[i] <= wdata & wr_mask(i);
            else if (tick)                          regs_q[i] <= regs_adv[i];
        end
    end

    // Marks the first cycle in which advanced values are visible.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_pulse <= 1'b0;
        else        sec_pulse <= tick;
    end

    // Same-cycle readback of the addressed register.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < REG_COUNT; i++)
            if (addr == ADDR_W'(i)) rdata = regs_q[i];
    end

    AST_SEC_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> regs_q[A_SEC] != $past(regs_q[A_SEC])); // R3
    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !$past(wr_en) && $past(regs_q[A_YEAR]) == 8'h99 && regs_q[A_YEAR] == 8'h00)
        |-> regs_q[A_MON][7] != $past(regs_q[A_MON][7])); // R9
    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !$past(wr_en) && $past(regs_q[A_DOW]) >= 8'd1 && $past(regs_q[A_DOW]) <= 8'd7)
        |-> (regs_q[A_DOW] >= 8'd1 && regs_q[A_DOW] <= 8'd7)); // R7
endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sqw_1hz;
    logic       sec_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit active = 0;

    // Behavioural reference state (binary integers).
    int m_cnt, m_s, m_m, m_h, m_dow, m_dt, m_mo, m_yr;
    bit m_md12, m_cent, m_pulse;

    always #10 clk = ~clk;

    bcd_timekeeper #(.TICKS_PER_SEC(T)) u_bcd_timekeeper (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sqw_en(sqw_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sqw_1hz(sqw_1hz), .sec_pulse(sec_pulse)
    );

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] m_reg(input int a);
        int hr;
        case (a)
            0: return i2b(m_s);
            1: return i2b(m_m);
            2: begin
                if (!m_md12) return i2b(m_h);
                hr = m_h % 12;
                if (hr == 0) hr = 12;
                return 8'h40 | (m_h >= 12 ? 8'h20 : 8'h00) | i2b(hr);
            end
            3: return 8'(m_dow);
            4: return i2b(m_dt);
            5: return {m_cent, 7'b0} | i2b(m_mo);
            6: return i2b(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R3 seconds";
            1: return "R4 minutes";
            2: return "R5 hours";
            3: return "R7 day-of-week";
            4: return "R8 date";
            5: return "R9 month";
            6: return "R9 year";
            default: return "R2 unused address";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_s = 0; m_m = 0; m_h = 0; m_md12 = 0; m_dow = 1;
        m_dt = 1; m_mo = 1; m_cent = 0; m_yr = 0; m_pulse = 0;
    endtask

    task automatic model_advance();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_m++;
        if (m_m < 60) return;
        m_m = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_dt++;
        if (m_dt <= days_in(m_mo, m_yr)) return;
        m_dt = 1; m_mo++;
        if (m_mo <= 12) return;
        m_mo = 1; m_yr++;
        if (m_yr < 100) return;
        m_yr = 0; m_cent = ~m_cent;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        logic [7:0] b;
        int hr;
        case (a)
            0: m_s = b2i(d & 8'h7F);
            1: m_m = b2i(d & 8'h7F);
            2: begin
                b = d & 8'h7F;
                m_md12 = b[6];
                if (b[6]) begin
                    hr = b2i(b & 8'h1F);
                    m_h = (hr % 12) + (b[5] ? 12 : 0);
                end else m_h = b2i(b & 8'h3F);
            end
            3: m_dow = int'(d & 8'h07);
            4: m_dt = b2i(d & 8'h3F);
            5: begin m_cent = d[7]; m_mo = b2i(d & 8'h1F); end
            6: m_yr = b2i(d);
            default: ;
        endcase
    endtask

    task automatic model_step();
        bit sw, tk;
        sw = wr_en && addr == 3'd0;
        tk = osc_en && m_cnt == T - 1 && !sw;
        if (sw) m_cnt = 0;
        else if (osc_en) m_cnt = (m_cnt == T - 1) ? 0 : m_cnt + 1;
        m_pulse = tk;
        if (tk) model_advance();
        if (wr_en) model_write(int'(addr), wdata);
    endtask

    // Compare outputs against the model at the falling edge.
    task automatic compare();
        chk(rdata == m_reg(int'(addr)), tag_of(int'(addr)), rdata, m_reg(int'(addr)));
        chk(sqw_1hz == (sqw_en && m_cnt >= T / 2), "R10 square wave", sqw_1hz,
            (sqw_en && m_cnt >= T / 2));
        chk(sec_pulse == m_pulse, "R3 second pulse", sec_pulse, m_pulse);
    endtask

    task automatic step(input bit o, input bit w, input int a, input logic [7:0] d);
        @(negedge clk);
        compare();
        osc_en = o; wr_en = w; addr = 3'(a); wdata = d;
        @(posedge clk);
        model_step();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        step(0, 1, a, d);
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        step(0, 0, a, 8'h00);
        #5;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1, 0, i % 7, 8'h00);
    endtask

    task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                           input logic [7:0] se);
        wr(6, yr); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, hr); wr(1, mi); wr(0, se);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int highs;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        rd_chk(0, 8'h00, "R1 seconds"); rd_chk(1, 8'h00, "R1 minutes");
        rd_chk(2, 8'h00, "R1 hours");   rd_chk(3, 8'h01, "R1 day-of-week");
        rd_chk(4, 8'h01, "R1 date");    rd_chk(5, 8'h01, "R1 month");
        rd_chk(6, 8'h00, "R1 year");

        // R2: masked writes and unused address
        wr(0, 8'hD9); rd_chk(0, 8'h59, "R2 seconds mask");
        wr(3, 8'h0D); rd_chk(3, 8'h05, "R2 dow mask");
        wr(5, 8'hE5); rd_chk(5, 8'h85, "R2 month mask");
        wr(4, 8'hC9); rd_chk(4, 8'h09, "R2 date mask");
        wr(2, 8'h92); rd_chk(2, 8'h12, "R2 hours mask");
        rd_chk(7, 8'h00, "R2 address 7");

        // R4 R5 R7 R8: non-leap February end at midnight
        set_all(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
        run(2 * T);
        rd_chk(0, 8'h00, "R4 seconds wrap"); rd_chk(1, 8'h00, "R4 minutes wrap");
        rd_chk(2, 8'h00, "R5 hour 23 wrap"); rd_chk(3, 8'h01, "R7 dow 7 wrap");
        rd_chk(4, 8'h01, "R8 Feb 28 wrap");  rd_chk(5, 8'h03, "R8 month advance");

        // R8: leap February
        set_all(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        run(T);
        rd_chk(4, 8'h29, "R8 leap Feb 29"); rd_chk(3, 8'h03, "R7 dow step");
        // R8: 30-day month
        set_all(8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        run(T);
        rd_chk(4, 8'h01, "R8 April 30 wrap"); rd_chk(5, 8'h05, "R8 April to May");

        // R9: year and century wrap
        set_all(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
        run(T);
        rd_chk(5, 8'h81, "R9 century flip"); rd_chk(6, 8'h00, "R9 year wrap");
        rd_chk(4, 8'h01, "R9 date");

        // R6: 12-hour sequence
        set_all(8'h10, 8'h06, 8'h10, 8'h03, 8'h51, 8'h59, 8'h59);
        run(T);
        rd_chk(2, 8'h72, "R6 11AM to 12PM");
        wr(1, 8'h59); wr(0, 8'h59);
        run(T);
        rd_chk(2, 8'h61, "R6 12PM to 1PM");
        wr(2, 8'h71); wr(1, 8'h59); wr(0, 8'h59);
        run(T);
        rd_chk(2, 8'h52, "R6 11PM to 12AM"); rd_chk(3, 8'h04, "R6 day advance");
        rd_chk(4, 8'h11, "R6 date advance");

        // R10: seconds write re-phases the square wave
        sqw_en = 1'b1;
        run(3);
        step(1, 1, 0, 8'h10);
        #5; chk(sqw_1hz == 1'b0, "R10 low after write", sqw_1hz, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00);
        #5; chk(sqw_1hz == 1'b1, "R10 high at half second", sqw_1hz, 1);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00);
        #5; chk(sec_pulse == 1'b0, "R10 no early advance", sec_pulse, 0);
        step(1, 0, 0, 8'h00);
        #5; chk(sec_pulse == 1'b1, "R3 pulse on advance", sec_pulse, 1);
        chk(rdata == 8'h11, "R10 advance after full second", rdata, 8'h11);

        // R11: disabled square wave stays low
        sqw_en = 1'b0;
        highs = 0;
        for (int i = 0; i < 2 * T; i++) begin
            step(1, 0, i % 7, 8'h00);
            #5; if (sqw_1hz) highs++;
        end
        chk(highs == 0, "R11 square wave disabled", highs, 0);

        // R12: write colliding with an advance
        set_all(8'h10, 8'h06, 8'h10, 8'h03, 8'h05, 8'h10, 8'h59);
        for (int i = 0; i < T - 1; i++) step(1, 0, 1, 8'h00);
        step(1, 1, 1, 8'h30);
        rd_chk(1, 8'h30, "R12 write wins"); rd_chk(0, 8'h00, "R12 others advance");
        rd_chk(2, 8'h05, "R12 hours unchanged");

        run(T);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule